// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and a 64K-word by 16-bit asynchronous static RAM that has one select per byte lane. The host issues one request at a time through a request/ready handshake. Each request carries an address, write data, a direction flag and two active-high byte enables. The controller turns the request into a strobe sequence on the memory pins: chip enable, output enable, write enable and the lower and upper lane selects, all active low. A read ends with a single-cycle response pulse that carries the captured data.

Every strobe phase lasts a whole number of clock cycles. Each phase length is worked out at elaboration from nanosecond limits and the clock period, in picoseconds, as the ceiling of the quotient with a floor of one cycle. The data bus is split into an input, an output and a driver enable. The controller turns its drivers on only after the memory has had time to float its outputs. After the write strobe rises, it holds the address and the data for one more cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip enable, output enable, write enable and both lane selects are high, the data drivers are off, `req_ready` is high and `rsp_valid` is low.
- R2: A read with a nonzero byte enable holds chip enable low, output enable low and write enable high for RD cycles, with the address steady. RD = max(ceil(t_aa/T), ceil(t_oe/T), ceil(t_rc/T)), where T is the clock period. The lower select is low exactly when `req_be[0]` is 1, and the upper select is low exactly when `req_be[1]` is 1.
- R3: Read data is captured at the clock edge that ends the RD window. `rsp_valid` is high for exactly the following cycle. Bits [7:0] of `rsp_rdata` come from the lower lane and bits [15:8] from the upper lane, and a lane that was not enabled returns zero.
- R4: A write with a nonzero byte enable holds chip enable low, write enable low and output enable high for WR cycles, with the lanes selected as in R2 and the address and write data driven. WR = max(ceil(t_wp/T), ceil(t_aw/T), ceil(t_dw/T), ceil(t_wc/T) - 1).
- R5: For exactly one cycle after write enable rises, the address, the driven data, chip enable and the lane selects stay unchanged. After that cycle everything is released.
- R6: The data drivers are never on while output enable is low. They turn on only after output enable has been high for at least ceil(t_hz/T) cycles. After a read, the controller waits that long before it accepts another request.
- R7: A request with both byte enables at 0 does not assert chip enable. A read of this kind produces `rsp_valid` with zero data in the cycle after acceptance. A write of this kind leaves the memory unchanged.
- R8: `req_ready` is high only while the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R9: A write leaves the memory contents of any lane whose byte enable is 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, so a request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = lower lane, bit 1 = upper lane |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data; disabled lanes are zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_in | input | 16 | Data arriving from the memory |
| mem_dq_out | output | 16 | Data going to the memory |
| mem_dq_oe | output | 1 | Controller data driver enable |

## Verification
The bench writes a single byte lane and then reads the whole word back. A controller that selected both lanes, or swapped the lanes, would overwrite or misplace the byte that should have been kept. Reads with only one lane enabled would expose a controller that returns the memory's undriven lane instead of zero. Zero-enable requests must complete without a chip select: a controller that strobed anyway, or that never answered a read, would either change memory or hang the host. A bus monitor flags any write drive that starts before output enable has been high for the float time. A memory model measures the write pulse, the data setup time and the hold cycle, so a short strobe or early release is reported.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_REC,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctl_state_e;

    // whole cycles covering t_ps, never fewer than one
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));

    a_r2_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
    parameter int LANE_W = 8
) (
    input  logic [1:0]          be,
    input  logic                cap_lb_n,
    input  logic                cap_ub_n,
    input  logic [2*LANE_W-1:0] dq_in,
    output logic [1:0]          sel_n,
    output logic [2*LANE_W-1:0] masked
);
    logic [1:0] cap_sel;
    assign cap_sel = {~cap_ub_n, ~cap_lb_n};

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign sel_n[g] = ~be[g];
        assign masked[g*LANE_W +: LANE_W] =
            cap_sel[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int CLK_PS    = 8000,
    parameter int T_RC_PS   = 12000,
    parameter int T_AA_PS   = 12000,
    parameter int T_OE_PS   = 6000,
    parameter int T_WC_PS   = 12000,
    parameter int T_WP_PS   = 10000,
    parameter int T_AW_PS   = 10000,
    parameter int T_DW_PS   = 8000,
    parameter int T_HZ_PS   = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    localparam int LANE_W = DATA_W / 2;
    localparam int RD_CYC = max2(max2(cycles_for(T_AA_PS, CLK_PS),
                                      cycles_for(T_OE_PS, CLK_PS)),
                                 cycles_for(T_RC_PS, CLK_PS));
    localparam int WR_CYC = max2(max2(cycles_for(T_WP_PS, CLK_PS),
                                      cycles_for(T_AW_PS, CLK_PS)),
                                 max2(cycles_for(T_DW_PS, CLK_PS),
                                      cycles_for(T_WC_PS, CLK_PS) - 1));
    localparam int HZ_CYC = cycles_for(T_HZ_PS, CLK_PS);
    localparam int CNT_W  = $clog2(max2(max2(RD_CYC, WR_CYC), HZ_CYC) + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              lb_n;
        logic              ub_n;
        logic              drive;
        logic              rsp;
    } ctl_t;

    ctl_t             r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic [1:0]       req_sel_n;
    logic [DATA_W-1:0] cap_data;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_lane_map #(.LANE_W(LANE_W)) u_lanes (
        .be       (req_be),
        .cap_lb_n (r_q.lb_n),
        .cap_ub_n (r_q.ub_n),
        .dq_in    (mem_dq_in),
        .sel_n    (req_sel_n),
        .masked   (cap_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rsp  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_be == 2'b00) begin
                        if (!req_write) begin
                            r_d.rsp   = 1'b1;
                            r_d.rdata = '0;
                        end
                    end else begin
                        r_d.addr = req_addr;
                        r_d.ce_n = 1'b0;
                        r_d.lb_n = req_sel_n[0];
                        r_d.ub_n = req_sel_n[1];
                        tmr_load = 1'b1;
                        if (req_write) begin
                            r_d.st    = ST_WR_PULSE;
                            r_d.we_n  = 1'b0;
                            r_d.wdata = req_wdata;
                            r_d.drive = 1'b1;
                            tmr_val   = CNT_W'(WR_CYC);
                        end else begin
                            r_d.st   = ST_RD_ACC;
                            r_d.oe_n = 1'b0;
                            tmr_val  = CNT_W'(RD_CYC);
                        end
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_last) begin
                    r_d.rdata = cap_data;
                    r_d.rsp   = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.lb_n  = 1'b1;
                    r_d.ub_n  = 1'b1;
                    r_d.st    = ST_RD_REC;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(HZ_CYC);
                end
            end
            ST_RD_REC: begin
                if (tmr_last) r_d.st = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    r_d.we_n = 1'b1;
                    r_d.st   = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                r_d.ce_n  = 1'b1;
                r_d.lb_n  = 1'b1;
                r_d.ub_n  = 1'b1;
                r_d.drive = 1'b0;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.lb_n  <= 1'b1;
            r_q.ub_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = r_q.rsp;
    assign rsp_rdata  = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_lb_n   = r_q.lb_n;
    assign mem_ub_n   = r_q.ub_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.drive;

    // R6: no drive while the memory may be driving
    a_r6_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    a_r6_drive_after_float: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));
    // R4: write strobe only with chip enable and driven data
    a_r4_we_with_ce_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));
    // R5: one hold cycle after the write strobe rises
    a_r5_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)
                             && mem_dq_oe && !mem_ce_n));
    // R8: busy while the chip is selected
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);
    // R7: chip enable never without a lane
    a_r7_ce_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !(mem_lb_n && mem_ub_n));
    // R2: read and write strobes exclusive
    a_r2_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    // R2: address steady while output enable is low
    a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));
endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
    localparam int PER_PS = 8000;

    function automatic int cdiv(input int t);
        int n;
        n = (t + PER_PS - 1) / PER_PS;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_N = mx(mx(cdiv(12000), cdiv(6000)), cdiv(12000));
    localparam int WR_N = mx(mx(cdiv(10000), cdiv(10000)), mx(cdiv(8000), cdiv(12000) - 1));
    localparam int HZ_N = cdiv(6000);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_in, mem_dq_out;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;

    always #4 clk = ~clk;

    sram_lane_ctrl u_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural memory and scoreboard
    logic [15:0] marr [int];
    logic [15:0] sb   [int];
    realtime t_wfall = 0.0, t_dchg = 0.0, t_achg = 0.0;

    function automatic logic [15:0] mem_word(input int a);
        return marr.exists(a) ? marr[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] sb_word(input int a);
        return sb.exists(a) ? sb[a] : 16'h0000;
    endfunction

    always @* begin
        logic [15:0] w;
        w = mem_word(int'(mem_addr));
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in = {(!mem_ub_n ? w[15:8] : 8'h5A), (!mem_lb_n ? w[7:0] : 8'hA5)};
        else
            mem_dq_in = 16'hC3C3;
    end

    always @(negedge mem_we_n) t_wfall = $realtime;
    always @(mem_dq_out)       t_dchg  = $realtime;
    always @(mem_addr)         t_achg  = $realtime;

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            logic [15:0] w;
            chk(($realtime - t_wfall) >= 10.0, "R4", "write pulse ns",
                32'($rtoi($realtime - t_wfall)), 32'd10);
            chk(($realtime - t_dchg) >= 8.0, "R4", "data setup ns",
                32'($rtoi($realtime - t_dchg)), 32'd8);
            chk(($realtime - t_achg) >= 10.0, "R4", "address setup ns",
                32'($rtoi($realtime - t_achg)), 32'd10);
            w = mem_word(int'(mem_addr));
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            marr[int'(mem_addr)] = w;
        end
    end

    // bus turnaround monitor (R6)
    int  oe_hi_run = 0;
    bit  prev_drv  = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            oe_hi_run = 0;
            prev_drv  = 1'b0;
        end else begin
            if (mem_dq_oe && !prev_drv)
                chk(oe_hi_run >= HZ_N, "R6", "float cycles before drive",
                    32'(oe_hi_run), 32'(HZ_N));
            if (mem_dq_oe)
                chk(mem_oe_n == 1'b1, "R6", "drive with oe low", 32'(mem_oe_n), 32'd1);
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
            prev_drv  = mem_dq_oe;
        end
    end

    task automatic issue(input logic wr, input logic [15:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] w;
        issue(1'b1, a, d, be);
        if (be == 2'b00) begin
            chk(mem_ce_n == 1'b1 && req_ready == 1'b1, "R7", "zero-enable write idle",
                32'({mem_ce_n, req_ready}), 32'b11);
            return;
        end
        for (int i = 0; i < WR_N; i++) begin
            chk(mem_we_n == 1'b0 && mem_ce_n == 1'b0 && mem_oe_n == 1'b1 &&
                mem_lb_n == !be[0] && mem_ub_n == !be[1] && mem_dq_oe == 1'b1 &&
                mem_dq_out == d && mem_addr == a && req_ready == 1'b0,
                "R4", "write strobe window",
                32'({mem_we_n, mem_ce_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}),
                32'({1'b0, 1'b0, 1'b1, !be[0], !be[1], 1'b1}));
            @(negedge clk);
        end
        chk(mem_we_n == 1'b1 && mem_ce_n == 1'b0 && mem_dq_oe == 1'b1 &&
            mem_dq_out == d && mem_addr == a, "R5", "hold cycle",
            32'({mem_we_n, mem_ce_n, mem_dq_oe}), 32'b101);
        @(negedge clk);
        chk(mem_ce_n == 1'b1 && mem_dq_oe == 1'b0 && req_ready == 1'b1 &&
            mem_lb_n && mem_ub_n, "R5", "release after hold",
            32'({mem_ce_n, mem_dq_oe, req_ready}), 32'b101);
        w = sb_word(int'(a));
        if (be[0]) w[7:0]  = d[7:0];
        if (be[1]) w[15:8] = d[15:8];
        sb[int'(a)] = w;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] be, input string req);
        logic [15:0] e;
        issue(1'b0, a, 16'h0, be);
        if (be == 2'b00) begin
            chk(rsp_valid == 1'b1 && rsp_rdata == 16'h0 && mem_ce_n == 1'b1, "R7",
                "zero-enable read response", 32'({rsp_valid, rsp_rdata}), 32'h10000);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R7", "zero-enable pulse width", 32'(rsp_valid), 32'd0);
            return;
        end
        for (int i = 0; i < RD_N; i++) begin
            chk(mem_ce_n == 1'b0 && mem_oe_n == 1'b0 && mem_we_n == 1'b1 &&
                mem_lb_n == !be[0] && mem_ub_n == !be[1] && mem_addr == a &&
                mem_dq_oe == 1'b0 && rsp_valid == 1'b0 && req_ready == 1'b0,
                "R2", "read strobe window",
                32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, rsp_valid}),
                32'({1'b0, 1'b0, 1'b1, !be[0], !be[1], 1'b0}));
            @(negedge clk);
        end
        e = sb_word(int'(a));
        if (!be[0]) e[7:0]  = 8'h00;
        if (!be[1]) e[15:8] = 8'h00;
        chk(rsp_valid == 1'b1 && rsp_rdata == e, req, "read data",
            32'({rsp_valid, rsp_rdata}), 32'({1'b1, e}));
        chk(mem_oe_n == 1'b1 && mem_ce_n == 1'b1, "R3", "strobes released",
            32'({mem_oe_n, mem_ce_n}), 32'b11);
        for (int i = 0; i < HZ_N; i++) begin
            if (i > 0) chk(req_ready == 1'b0, "R6", "recovery busy", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R3", "pulse one cycle, then idle",
            32'({req_ready, rsp_valid}), 32'b10);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n &&
            !mem_dq_oe && req_ready && !rsp_valid, "R1", "reset state",
            32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid}),
            32'b11111010);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && req_ready, "R1", "idle after reset", 32'({mem_ce_n, req_ready}), 32'b11);

        do_write(16'h1234, 16'hBEEF, 2'b11);
        do_read (16'h1234, 2'b11, "R3");
        do_write(16'h1234, 16'h00CC, 2'b01);
        do_read (16'h1234, 2'b11, "R9");
        do_write(16'h1234, 16'h7711, 2'b10);
        do_read (16'h1234, 2'b11, "R9");
        do_read (16'h1234, 2'b01, "R3");
        do_read (16'h1234, 2'b10, "R3");
        do_write(16'h1234, 16'hFFFF, 2'b00);
        do_read (16'h1234, 2'b11, "R7");
        do_read (16'h1234, 2'b00, "R7");
        do_write(16'hFFFF, 16'hA55A, 2'b11);
        do_write(16'h0000, 16'h0F0F, 2'b11);
        do_read (16'hFFFF, 2'b11, "R3");
        do_read (16'h0000, 2'b10, "R3");
        do_read (16'h4321, 2'b11, "R2");

        chk(mem_word(32'h1234) == 16'h77CC, "R9", "memory model contents",
            32'(mem_word(32'h1234)), 32'h77CC);
        summary();
        $finish;
    end
endmodule